// File: doc/BRIEF.md
# Control Latch and System Address Decoder

This block sits between a 16-bit processor bus and the system's memories and peripherals. It works out which device a bus cycle targets and raises that device's select: boot ROM, main RAM, the storage card registers, the page-mapper registers, the serial controller and the video read and write ports. It also drives a RAM write enable that a per-page protect flag can block, and a one-wait-state request for the slow devices.

An eight-bit control latch sits in the bit-serial I/O space. Each I/O bit write changes one latch bit. Three bits steer the decoder. The first takes the ROM out of the low half of memory. The second turns the page mapper on. The third sets user mode, which shuts out every privileged peripheral and arms RAM write protection. The remaining five bits are general-purpose outputs. With the ROM enabled, writes to the low half go to RAM. Software can therefore copy the ROM into the RAM underneath it, disable the ROM and carry on from RAM.

Top module: `bus_ctl_decoder`

## Requirements
- R1: Reset (rst_ni low) clears all eight latch bits, so every latch output reads 0.
- R2: A write with io_wr_i high, mem_cycle_i low and an address whose bits 15:7 are zero and bit 6 is one loads io_data_i into latch bit addr_i[3:1] at the clock edge and leaves the other bits unchanged. A write on a memory cycle, or one outside that window, changes nothing.
- R3: Latch bit 0 drives rom_off_o, bit 1 drives map_en_o, bit 2 drives user_o, and bits 3 to 7 drive spare_o[0] to spare_o[4].
- R4: rom_sel_o is high on a memory cycle with addr_i below 0x8000, rom_off_o low and wr_i low.
- R5: ram_sel_o is high on a memory cycle in either of two cases: addr_i is at or above 0x8000 outside the 0xFE00–0xFEFF page, or addr_i is below 0x8000 and either rom_off_o or wr_i is high.
- R6: On a memory cycle in page 0xFE, addr_i[7:6]=00 raises card_sel_o and addr_i[7:6]=01 raises map_sel_o.
- R7: On a memory cycle in page 0xFE with addr_i[7]=1, vid_rd_o follows rd_i and vid_wr_o follows wr_i.
- R8: ser_sel_o is high on a non-memory cycle with addr_i below 0x0040.
- R9: While user_o is high, card_sel_o, map_sel_o, ser_sel_o, vid_rd_o and vid_wr_o stay low. Latch writes still take effect in user mode.
- R10: ram_we_o equals wr_i, except that it is low whenever protect_i and user_o are both high.
- R11: wait_req_o is high exactly when rom_sel_o or card_sel_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address (memory byte or I/O bit address) |
| mem_cycle_i | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| rd_i | input | 1 | Memory read strobe |
| wr_i | input | 1 | Memory write strobe |
| io_wr_i | input | 1 | I/O bit-write enable |
| io_data_i | input | 1 | I/O bit-write data |
| protect_i | input | 1 | Page protect flag from the mapper |
| rom_sel_o | output | 1 | ROM select |
| ram_sel_o | output | 1 | RAM select |
| card_sel_o | output | 1 | Storage card select |
| map_sel_o | output | 1 | Mapper register select |
| ser_sel_o | output | 1 | Serial controller select |
| vid_rd_o | output | 1 | Video read select |
| vid_wr_o | output | 1 | Video write select |
| ram_we_o | output | 1 | Protected RAM write enable |
| wait_req_o | output | 1 | One-wait-state request |
| rom_off_o | output | 1 | Latch bit 0, ROM disabled |
| map_en_o | output | 1 | Latch bit 1, mapper enabled |
| user_o | output | 1 | Latch bit 2, user mode |
| spare_o | output | 5 | Latch bits 3 to 7 |

## Verification
The bench builds the block with its default 16-bit address and eight-bit latch. At that size every high address byte can be swept against the page-boundary low bytes 0x00, 0x3F, 0x40, 0x7F, 0x80 and 0xFF. The sweep covers all four combinations of ROM-off and user mode, both cycle kinds, read and write strobes and both protect values. This exposes every region edge, user-mode blocking, and the write-under-ROM path. Latch tests write through aliased addresses and rejected addresses, and also issue a writes on a memory cycle.

// File: rtl/bus_ctl_pkg.sv
package bus_ctl_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned PAGE_W   = 8;
  localparam logic [PAGE_W-1:0] IO_PAGE = 8'hFE;
  localparam int unsigned CTL_BITS = 3;

  typedef enum logic [1:0] {
    SUB_CARD = 2'b00,
    SUB_MAP  = 2'b01,
    SUB_VID0 = 2'b10,
    SUB_VID1 = 2'b11
  } sub_e;

  typedef struct packed {
    logic rom;
    logic ram;
    logic card;
    logic map;
    logic vid_rd;
    logic vid_wr;
  } mem_sel_t;
endpackage

// File: rtl/ctl_latch.sv
module ctl_latch #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wen_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             data_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q_q[g] <= 1'b0;
      else if (wen_i && idx_i == IDX_W'(g))          q_q[g] <= data_i;
    end
  end

  assign q_o = q_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_i |=> $stable(q_q));
  assert_single_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_i |=> $countones(q_q ^ $past(q_q)) <= 1);
  assert_bit_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_i |=> q_q[$past(idx_i)] == $past(data_i));
endmodule

// File: rtl/io_decode.sv
module io_decode
  import bus_ctl_pkg::*;
#(
  parameter int unsigned LATCH_W = 8,
  localparam int unsigned IDX_W = $clog2(LATCH_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:6] addr_hi_i,
  input  logic [IDX_W:1]    addr_bit_i,
  input  logic              mem_cycle_i,
  input  logic              io_wr_i,
  input  logic              user_i,
  output logic              ser_sel_o,
  output logic              latch_wen_o,
  output logic [IDX_W-1:0]  latch_idx_o
);
  logic low_block;  // bit addresses 0x0000-0x007F
  assign low_block = (addr_hi_i[ADDR_W-1:7] == '0) && !mem_cycle_i;

  assign ser_sel_o   = low_block && !addr_hi_i[6] && !user_i;
  // latch stays writable in user mode
  assign latch_wen_o = low_block && addr_hi_i[6] && io_wr_i;
  assign latch_idx_o = addr_bit_i;

  assert_ser_io_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sel_o |-> !mem_cycle_i && !latch_wen_o);
  assert_ser_user_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_i |-> !ser_sel_o);
endmodule

// File: rtl/mem_decode.sv
module mem_decode
  import bus_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:6] addr_hi_i,
  input  logic              mem_cycle_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              rom_off_i,
  input  logic              user_i,
  input  logic              protect_i,
  output mem_sel_t          sel_o,
  output logic              ram_we_o,
  output logic              wait_req_o
);
  logic low_half, io_page, priv_ok;
  sub_e sub;

  assign low_half = !addr_hi_i[ADDR_W-1];
  assign io_page  = addr_hi_i[ADDR_W-1 -: PAGE_W] == IO_PAGE;
  assign sub      = sub_e'(addr_hi_i[7:6]);
  assign priv_ok  = mem_cycle_i && io_page && !user_i;

  always_comb begin
    sel_o        = '0;
    sel_o.rom    = mem_cycle_i && low_half && !rom_off_i && !wr_i;
    // writes under an enabled ROM land in RAM
    sel_o.ram    = mem_cycle_i && (low_half ? (rom_off_i || wr_i) : !io_page);
    sel_o.card   = priv_ok && sub == SUB_CARD;
    sel_o.map    = priv_ok && sub == SUB_MAP;
    sel_o.vid_rd = priv_ok && addr_hi_i[7] && rd_i;
    sel_o.vid_wr = priv_ok && addr_hi_i[7] && wr_i;
  end

  assign ram_we_o   = wr_i && !(protect_i && user_i);
  assign wait_req_o = sel_o.rom || sel_o.card;

  assert_one_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_o.rom, sel_o.ram, sel_o.card, sel_o.map, sel_o.vid_rd | sel_o.vid_wr}));
  assert_rom_region_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o.rom |-> mem_cycle_i && low_half && !rom_off_i);
  assert_user_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_i |-> !(sel_o.card || sel_o.map || sel_o.vid_rd || sel_o.vid_wr));
  assert_protect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_i && user_i) |-> !ram_we_o);
  assert_wait_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req_o |-> mem_cycle_i && (low_half || io_page));
endmodule

// File: rtl/bus_ctl_decoder.sv
module bus_ctl_decoder
  import bus_ctl_pkg::*;
#(
  parameter int unsigned LATCH_W = 8,
  localparam int unsigned IDX_W   = $clog2(LATCH_W),
  localparam int unsigned SPARE_W = LATCH_W - CTL_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               mem_cycle_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               io_wr_i,
  input  logic               io_data_i,
  input  logic               protect_i,
  output logic               rom_sel_o,
  output logic               ram_sel_o,
  output logic               card_sel_o,
  output logic               map_sel_o,
  output logic               ser_sel_o,
  output logic               vid_rd_o,
  output logic               vid_wr_o,
  output logic               ram_we_o,
  output logic               wait_req_o,
  output logic               rom_off_o,
  output logic               map_en_o,
  output logic               user_o,
  output logic [SPARE_W-1:0] spare_o
);
  logic [LATCH_W-1:0] ctl_q;
  logic               latch_wen;
  logic [IDX_W-1:0]   latch_idx;
  mem_sel_t           msel;
  logic               addr_unused;

  assign addr_unused = ^{addr_i[5:IDX_W+1], addr_i[0]};

  io_decode #(.LATCH_W(LATCH_W)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_hi_i   (addr_i[ADDR_W-1:6]),
    .addr_bit_i  (addr_i[IDX_W:1]),
    .mem_cycle_i (mem_cycle_i),
    .io_wr_i     (io_wr_i),
    .user_i      (user_o),
    .ser_sel_o   (ser_sel_o),
    .latch_wen_o (latch_wen),
    .latch_idx_o (latch_idx)
  );

  ctl_latch #(.WIDTH(LATCH_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wen_i  (latch_wen),
    .idx_i  (latch_idx),
    .data_i (io_data_i),
    .q_o    (ctl_q)
  );

  assign rom_off_o = ctl_q[0];
  assign map_en_o  = ctl_q[1];
  assign user_o    = ctl_q[2];
  assign spare_o   = ctl_q[LATCH_W-1:CTL_BITS];

  mem_decode u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_hi_i   (addr_i[ADDR_W-1:6]),
    .mem_cycle_i (mem_cycle_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .rom_off_i   (rom_off_o),
    .user_i      (user_o),
    .protect_i   (protect_i),
    .sel_o       (msel),
    .ram_we_o    (ram_we_o),
    .wait_req_o  (wait_req_o)
  );

  assign rom_sel_o  = msel.rom;
  assign ram_sel_o  = msel.ram;
  assign card_sel_o = msel.card;
  assign map_sel_o  = msel.map;
  assign vid_rd_o   = msel.vid_rd;
  assign vid_wr_o   = msel.vid_wr;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> ctl_q == '0);
endmodule

// File: tb/tb_bus_ctl_decoder.sv
`timescale 1ns/1ps
module tb_bus_ctl_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mem = 1'b0, rd = 1'b0, wr = 1'b0, iow = 1'b0, iod = 1'b0, prot = 1'b0;
  logic rom_sel, ram_sel, card_sel, map_sel, ser_sel, vrd, vwr, ram_we, wreq;
  logic rom_off, map_en, user;
  logic [4:0] spare;

  int checks = 0, fails = 0;
  logic [7:0] exp_q = '0;

  always #10 clk = ~clk;

  bus_ctl_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mem_cycle_i(mem), .rd_i(rd), .wr_i(wr),
    .io_wr_i(iow), .io_data_i(iod), .protect_i(prot),
    .rom_sel_o(rom_sel), .ram_sel_o(ram_sel), .card_sel_o(card_sel), .map_sel_o(map_sel),
    .ser_sel_o(ser_sel), .vid_rd_o(vrd), .vid_wr_o(vwr), .ram_we_o(ram_we),
    .wait_req_o(wreq), .rom_off_o(rom_off), .map_en_o(map_en), .user_o(user), .spare_o(spare)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 40)
        $display("FAIL %s addr=%h mem=%0b rd=%0b wr=%0b prot=%0b actual=%0b expected=%0b",
                 tag, addr, mem, rd, wr, prot, act, exp);
    end
  endtask

  task automatic chk_latch(input string tag);
    checks++;
    if ({spare, user, map_en, rom_off} !== exp_q) begin
      fails++;
      $display("FAIL %s latch actual=%h expected=%h", tag, {spare, user, map_en, rom_off}, exp_q);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic d, input logic on_mem);
    @(negedge clk);
    addr = a; iod = d; iow = 1'b1; mem = on_mem;
    @(negedge clk);
    iow = 1'b0; mem = 1'b0;
    if (!on_mem && a[15:7] == 0 && a[6]) exp_q[a[3:1]] = d;
  endtask

  task automatic decode_check();
    logic lo, fe, e_rom, e_card, e_user;
    #1;
    e_user = exp_q[2];
    lo = (addr < 16'h8000);
    fe = (addr[15:8] == 8'hFE);
    e_rom  = mem && lo && !exp_q[0] && !wr;
    e_card = mem && fe && addr[7:6] == 2'b00 && !e_user;
    chk(rom_sel, e_rom, "R4");
    chk(ram_sel, mem && (lo ? (exp_q[0] || wr) : !fe), "R5");
    chk(card_sel, e_card, "R6");
    chk(map_sel, mem && fe && addr[7:6] == 2'b01 && !e_user, "R6");
    chk(vrd, mem && fe && addr[7] && rd && !e_user, "R7");
    chk(vwr, mem && fe && addr[7] && wr && !e_user, "R7");
    chk(ser_sel, !mem && addr < 16'h0040 && !e_user, "R8");
    if (e_user) chk(card_sel | map_sel | ser_sel | vrd | vwr, 1'b0, "R9");
    chk(ram_we, wr && !(prot && e_user), "R10");
    chk(wreq, e_rom || e_card, "R11");
  endtask

  initial begin : watchdog
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] lo_set [6];
    lo_set = '{8'h00, 8'h3F, 8'h40, 8'h7F, 8'h80, 8'hFF};
    repeat (3) @(negedge clk);
    chk_latch("R1");  // held in reset
    rst_n = 1'b1;
    @(negedge clk);
    chk_latch("R1");

    // R3 mapping: one bit at a time through base addresses
    for (int b = 0; b < 8; b++) begin
      io_write(16'h0040 + 16'(2*b), 1'b1, 1'b0);
      chk_latch("R3");
      io_write(16'h0040 + 16'(2*b), 1'b0, 1'b0);
      chk_latch("R2");
    end
    // R2 aliases and rejects
    io_write(16'h007E, 1'b1, 1'b0); chk_latch("R2");  // bit 7
    io_write(16'h005B, 1'b1, 1'b0); chk_latch("R2");  // bit 5
    io_write(16'h0066, 1'b1, 1'b0); chk_latch("R2");  // bit 3
    io_write(16'h0042, 1'b1, 1'b1); chk_latch("R2");  // memory cycle: ignored
    io_write(16'h0080, 1'b1, 1'b0); chk_latch("R2");  // outside window
    io_write(16'h0142, 1'b1, 1'b0); chk_latch("R2");  // outside window
    io_write(16'h0030, 1'b1, 1'b0); chk_latch("R2");  // serial range
    io_write(16'h007E, 1'b0, 1'b0); chk_latch("R2");

    // decode sweep over latch states
    for (int st = 0; st < 4; st++) begin
      io_write(16'h0040, st[0], 1'b0);
      io_write(16'h0044, st[1], 1'b0);  // also exercises writes in user mode
      chk_latch("R9");
      for (int hi = 0; hi < 256; hi++)
        for (int li = 0; li < 6; li++)
          for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
              @(negedge clk);
              addr = {hi[7:0], lo_set[li]};
              mem = m[0]; rd = (s == 1); wr = (s >= 2); prot = (s == 3) || (s == 0 && hi[0]);
              decode_check();
            end
      @(negedge clk);
      mem = 1'b0; rd = 1'b0; wr = 1'b0; prot = 1'b0;
    end

    // reset mid-run clears latch
    io_write(16'h0048, 1'b1, 1'b0);
    io_write(16'h0042, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; exp_q = '0;
    #1 chk_latch("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_latch("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule